// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block handles the hardware side of taking and leaving an interrupt on a segmented 16-bit processor. While it is idle it looks at seven request sources and serves the most urgent one. These are a divide fault, a breakpoint, an overflow trap, a software interrupt with an 8-bit operand, a non-maskable request, a maskable external request, and the single-step trap. It saves the machine state on the stack with word writes. It then fetches the handler's code segment and instruction pointer from a vector table at address zero. On a return request it pops the saved state back.

The surrounding core presents its current CS, IP, SS, SP and flags on input ports. When `done` pulses, the core loads the new CS, IP, SP and flags from the output ports. All memory traffic uses one word-wide port with a request/ready handshake, so any number of wait states can be inserted. During a maskable request the same port also runs the acknowledge cycle that returns the interrupt type.

Top module: `intr_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `done` and `mem_req` are all low.
- R2: An entry writes three words in this order: the flags to linear address SS*16+SP-2, CS to SS*16+SP-4, and IP to SS*16+SP-6. Each linear address is taken modulo 2^20. The SP reported at `done` is SP-6.
- R3: After the three writes, an entry reads the new IP from address type*4 and then the new CS from type*4+2. Both addresses lie below 400h. The values read appear on `new_ip` and `new_cs` at `done`.
- R4: The flags word pushed on the stack is the unmodified input. The `new_flags` reported at entry completion equal the input with bit 8 (trace) and bit 9 (interrupt enable) cleared and all other bits unchanged.
- R5: The types are fixed for five sources: divide fault 0, single-step 1, non-maskable 2, breakpoint 3, overflow 4. A software interrupt uses `int_type`.
- R6: A maskable request with flags bit 9 set first performs an acknowledge read (`mem_inta`=1, `mem_we`=0, address 0) and takes the type from `mem_rdata[7:0]`. With bit 9 clear the request is dropped, and `busy` and `mem_req` stay low.
- R7: When several requests arrive in the same idle cycle, only one is served. The order, highest first, is divide, breakpoint, overflow, software, non-maskable, maskable, single-step. The others are dropped.
- R8: `step_done` raises type 1 only while flags bit 8 is set. Otherwise it has no effect.
- R9: A return reads IP from SS*16+SP, then CS from SS*16+SP+2, then flags from SS*16+SP+4. It reports these values and SP+6 at `done`.
- R10: While `mem_req` is high and `mem_ready` is low, the address, direction and write data are held, and the sequence does not advance.
- R11: `busy` rises the cycle after a request is accepted and falls when `done` pulses for one cycle. Requests seen while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_err | input | 1 | Divide fault request |
| bkpt_req | input | 1 | Breakpoint request |
| ovf_req | input | 1 | Overflow trap request |
| int_req | input | 1 | Software interrupt request |
| int_type | input | 8 | Software interrupt operand |
| nmi_req | input | 1 | Non-maskable request |
| intr_req | input | 1 | Maskable external request |
| step_done | input | 1 | Instruction retired (single-step source) |
| iret_req | input | 1 | Return from interrupt request |
| cpu_cs | input | 16 | Current code segment |
| cpu_ip | input | 16 | Current instruction pointer (return address) |
| cpu_ss | input | 16 | Stack segment |
| cpu_sp | input | 16 | Stack pointer |
| cpu_flags | input | 16 | Flags word (bit 8 trace, bit 9 interrupt enable) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: new state valid |
| new_cs | output | 16 | Code segment to load |
| new_ip | output | 16 | Instruction pointer to load |
| new_sp | output | 16 | Stack pointer to load |
| new_flags | output | 16 | Flags to load |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_inta | output | 1 | Current read is an interrupt acknowledge |
| mem_addr | output | 20 | Linear word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Completes the current transaction at the clock edge |

## Verification
A request driven before a rising edge is accepted at that edge. `busy` and the first `mem_req` are visible in the next cycle. Each transaction then lasts one cycle plus the wait states the memory model inserts, and it completes at the edge where `mem_ready` is high. `done` and the new state appear in the cycle after the last transaction completes. The bench drives and samples only on falling edges. Its memory model answers at the falling edge and compares each transaction against the expected queue there, so every check lands in the cycle where the result is due, whatever wait count is in use.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned NSRC = 7;
  localparam int unsigned SRC_DIV  = 0;
  localparam int unsigned SRC_BKPT = 1;
  localparam int unsigned SRC_OVF  = 2;
  localparam int unsigned SRC_SWI  = 3;
  localparam int unsigned SRC_NMI  = 4;
  localparam int unsigned SRC_INTR = 5;
  localparam int unsigned SRC_STEP = 6;

  localparam logic [7:0] TYPE_DIV  = 8'd0;
  localparam logic [7:0] TYPE_STEP = 8'd1;
  localparam logic [7:0] TYPE_NMI  = 8'd2;
  localparam logic [7:0] TYPE_BKPT = 8'd3;
  localparam logic [7:0] TYPE_OVF  = 8'd4;

  localparam int unsigned TF_POS = 8;
  localparam int unsigned IF_POS = 9;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK,
    ST_PSH_F,
    ST_PSH_CS,
    ST_PSH_IP,
    ST_VEC_IP,
    ST_VEC_CS,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_F
  } seq_st_t;
endpackage

// File: rtl/intr_arb.sv
module intr_arb #(
  parameter int unsigned NSRC = 7,
  parameter int unsigned TW   = 8
) (
  input  logic [NSRC-1:0]         req,
  input  logic [NSRC-1:0][TW-1:0] src_type,
  output logic [NSRC-1:0]         grant,
  output logic                    any,
  output logic [TW-1:0]           sel_type
);
  // index 0 is the most urgent source
  for (genvar i = 0; i < NSRC; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any = |req;

  always_comb begin
    sel_type = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) sel_type = sel_type | src_type[i];
    end
  end

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant)); // R7
  end
endmodule

// File: rtl/intr_agen.sv
module intr_agen
  import intr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 8,
  localparam int unsigned AW = DW + 4
) (
  input  seq_st_t         st,
  input  logic [DW-1:0]   ss,
  input  logic [DW-1:0]   sp,
  input  logic [TW-1:0]   vtype,
  output logic [AW-1:0]   addr
);
  logic [DW-1:0] sp_eff;
  logic [AW-1:0] seg_base;
  logic [AW-1:0] vec_base;

  always_comb begin
    seg_base = {ss, 4'h0};
    vec_base = AW'({vtype, 2'b00});
    case (st)
      ST_PSH_F, ST_PSH_CS, ST_PSH_IP: sp_eff = sp - DW'(2);
      default:                        sp_eff = sp;
    endcase
    case (st)
      ST_IDLE, ST_ACK: addr = '0;
      ST_VEC_IP:       addr = vec_base;
      ST_VEC_CS:       addr = vec_base + AW'(2);
      default:         addr = seg_base + AW'(sp_eff);
    endcase
  end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 8,
  localparam int unsigned AW = DW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          div_err,
  input  logic          bkpt_req,
  input  logic          ovf_req,
  input  logic          int_req,
  input  logic [TW-1:0] int_type,
  input  logic          nmi_req,
  input  logic          intr_req,
  input  logic          step_done,
  input  logic          iret_req,
  input  logic [DW-1:0] cpu_cs,
  input  logic [DW-1:0] cpu_ip,
  input  logic [DW-1:0] cpu_ss,
  input  logic [DW-1:0] cpu_sp,
  input  logic [DW-1:0] cpu_flags,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] new_cs,
  output logic [DW-1:0] new_ip,
  output logic [DW-1:0] new_sp,
  output logic [DW-1:0] new_flags,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_inta,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  localparam logic [DW-1:0] TIF_MASK = (DW'(1) << TF_POS) | (DW'(1) << IF_POS);

  seq_st_t        st_q;
  logic [DW-1:0]  cs_q, ip_q, ss_q, sp_q, fl_q;
  logic [TW-1:0]  vtype_q;
  logic           done_q;

  logic [NSRC-1:0]         src_req;
  logic [NSRC-1:0][TW-1:0] src_type;
  logic [NSRC-1:0]         grant;
  logic                    any_req;
  logic [TW-1:0]           sel_type;
  logic                    hs;

  always_comb begin
    src_req            = '0;
    src_req[SRC_DIV]   = div_err;
    src_req[SRC_BKPT]  = bkpt_req;
    src_req[SRC_OVF]   = ovf_req;
    src_req[SRC_SWI]   = int_req;
    src_req[SRC_NMI]   = nmi_req;
    src_req[SRC_INTR]  = intr_req & cpu_flags[IF_POS];
    src_req[SRC_STEP]  = step_done & cpu_flags[TF_POS];
    src_type           = '0;
    src_type[SRC_DIV]  = TW'(TYPE_DIV);
    src_type[SRC_BKPT] = TW'(TYPE_BKPT);
    src_type[SRC_OVF]  = TW'(TYPE_OVF);
    src_type[SRC_SWI]  = int_type;
    src_type[SRC_NMI]  = TW'(TYPE_NMI);
    src_type[SRC_STEP] = TW'(TYPE_STEP);
  end

  intr_arb #(.NSRC(NSRC), .TW(TW)) u_arb (
    .req      (src_req),
    .src_type (src_type),
    .grant    (grant),
    .any      (any_req),
    .sel_type (sel_type)
  );

  intr_agen #(.DW(DW), .TW(TW)) u_agen (
    .st    (st_q),
    .ss    (ss_q),
    .sp    (sp_q),
    .vtype (vtype_q),
    .addr  (mem_addr)
  );

  assign hs = mem_req & mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cs_q    <= '0;
      ip_q    <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
      fl_q    <= '0;
      vtype_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (any_req || iret_req) begin
            cs_q <= cpu_cs;
            ip_q <= cpu_ip;
            ss_q <= cpu_ss;
            sp_q <= cpu_sp;
            fl_q <= cpu_flags;
          end
          if (any_req) begin
            vtype_q <= sel_type;
            st_q    <= grant[SRC_INTR] ? ST_ACK : ST_PSH_F;
          end else if (iret_req) begin
            st_q <= ST_POP_IP;
          end
        end
        ST_ACK: if (hs) begin
          vtype_q <= mem_rdata[TW-1:0];
          st_q    <= ST_PSH_F;
        end
        ST_PSH_F: if (hs) begin
          sp_q <= sp_q - DW'(2);
          fl_q <= fl_q & ~TIF_MASK;
          st_q <= ST_PSH_CS;
        end
        ST_PSH_CS: if (hs) begin
          sp_q <= sp_q - DW'(2);
          st_q <= ST_PSH_IP;
        end
        ST_PSH_IP: if (hs) begin
          sp_q <= sp_q - DW'(2);
          st_q <= ST_VEC_IP;
        end
        ST_VEC_IP: if (hs) begin
          ip_q <= mem_rdata;
          st_q <= ST_VEC_CS;
        end
        ST_VEC_CS: if (hs) begin
          cs_q   <= mem_rdata;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_POP_IP: if (hs) begin
          ip_q <= mem_rdata;
          sp_q <= sp_q + DW'(2);
          st_q <= ST_POP_CS;
        end
        ST_POP_CS: if (hs) begin
          cs_q <= mem_rdata;
          sp_q <= sp_q + DW'(2);
          st_q <= ST_POP_F;
        end
        ST_POP_F: if (hs) begin
          fl_q   <= mem_rdata;
          sp_q   <= sp_q + DW'(2);
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = (st_q != ST_IDLE);
    mem_we   = (st_q == ST_PSH_F) || (st_q == ST_PSH_CS) || (st_q == ST_PSH_IP);
    mem_inta = (st_q == ST_ACK);
    case (st_q)
      ST_PSH_F:  mem_wdata = fl_q;
      ST_PSH_CS: mem_wdata = cs_q;
      ST_PSH_IP: mem_wdata = ip_q;
      default:   mem_wdata = '0;
    endcase
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign new_cs    = cs_q;
  assign new_ip    = ip_q;
  assign new_sp    = sp_q;
  assign new_flags = fl_q;

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst) (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R11
  AST_ACK_IS_READ: assert property (@(posedge clk) disable iff (rst) mem_inta |-> (mem_req && !mem_we)); // R6
  AST_VECTOR_WINDOW: assert property (@(posedge clk) disable iff (rst) (mem_req && !mem_we && !mem_inta && ((st_q == ST_VEC_IP) || (st_q == ST_VEC_CS))) |-> (mem_addr < AW'(1024))); // R3
  AST_MASKED_INTR: assert property (@(posedge clk) disable iff (rst) (!busy && intr_req && !cpu_flags[IF_POS] && !div_err && !bkpt_req && !ovf_req && !int_req && !nmi_req && !step_done && !iret_req) |=> !busy); // R6
endmodule

// File: tb/intr_seq_bench.sv
module intr_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic        div_err, bkpt_req, ovf_req, int_req, nmi_req, intr_req, step_done, iret_req;
  logic [7:0]  int_type;
  logic [15:0] cpu_cs, cpu_ip, cpu_ss, cpu_sp, cpu_flags;
  logic        busy, done, mem_req, mem_we, mem_inta;
  logic [15:0] new_cs, new_ip, new_sp, new_flags, mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ready;
  logic [19:0] mem_addr;

  intr_seq u_intr_seq (
    .clk(clk), .rst(rst), .div_err(div_err), .bkpt_req(bkpt_req), .ovf_req(ovf_req),
    .int_req(int_req), .int_type(int_type), .nmi_req(nmi_req), .intr_req(intr_req),
    .step_done(step_done), .iret_req(iret_req), .cpu_cs(cpu_cs), .cpu_ip(cpu_ip),
    .cpu_ss(cpu_ss), .cpu_sp(cpu_sp), .cpu_flags(cpu_flags), .busy(busy), .done(done),
    .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp), .new_flags(new_flags),
    .mem_req(mem_req), .mem_we(mem_we), .mem_inta(mem_inta), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  typedef struct { bit inta; bit we; logic [19:0] addr; logic [15:0] wd; string tag; } xact_t;
  typedef struct { logic [15:0] cs; logic [15:0] ip; logic [15:0] sp; logic [15:0] fl; string tag; } res_t;

  xact_t exp_q[$];
  res_t  res_q[$];
  logic [15:0] bmem [logic [19:0]];
  int checks = 0;
  int errors = 0;
  int waits = 0;
  logic [7:0] bus_type = 8'h00;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] vip(input int t);
    return 16'(32'h4000 + t * 6);
  endfunction
  function automatic logic [15:0] vcs(input int t);
    return 16'(32'hC001 + t * 16);
  endfunction
  function automatic logic [19:0] lin(input logic [15:0] s, input logic [15:0] p);
    return {s, 4'h0} + {4'h0, p};
  endfunction
  function automatic logic [15:0] rd(input logic [19:0] a);
    return bmem.exists(a) ? bmem[a] : 16'h0000;
  endfunction

  // memory model and transaction scoreboard
  int wcnt = 0;
  bit prev_wait = 1'b0;
  logic [19:0] prev_addr;
  always @(negedge clk) begin
    if (rst || !mem_req) begin
      mem_ready = 1'b0;
      wcnt = 0;
      prev_wait = 1'b0;
    end else begin
      if (prev_wait) chk("R10", "address held during wait", 32'(mem_addr), 32'(prev_addr));
      if (wcnt >= waits) begin
        mem_ready = 1'b1;
        wcnt = 0;
        prev_wait = 1'b0;
        if (mem_inta) mem_rdata = {8'h00, bus_type};
        else if (!mem_we) mem_rdata = rd(mem_addr);
        if (mem_we) bmem[mem_addr] = mem_wdata;
        if (exp_q.size() == 0) begin
          chk("R11", "unexpected transaction addr", 32'(mem_addr), 32'hFFFFFFFF);
        end else begin
          xact_t e;
          e = exp_q.pop_front();
          chk(e.tag, "inta", 32'(mem_inta), 32'(e.inta));
          chk(e.tag, "we", 32'(mem_we), 32'(e.we));
          chk(e.tag, "addr", 32'(mem_addr), 32'(e.addr));
          if (e.we) chk(e.tag, "wdata", 32'(mem_wdata), 32'(e.wd));
        end
      end else begin
        mem_ready = 1'b0;
        wcnt++;
        prev_wait = 1'b1;
        prev_addr = mem_addr;
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      chk("R11", "busy low at done", 32'(busy), 32'h0);
      if (res_q.size() == 0) begin
        chk("R11", "unexpected done", 32'h1, 32'h0);
      end else begin
        res_t r;
        r = res_q.pop_front();
        chk(r.tag, "new_cs", 32'(new_cs), 32'(r.cs));
        chk(r.tag, "new_ip", 32'(new_ip), 32'(r.ip));
        chk(r.tag, "new_sp", 32'(new_sp), 32'(r.sp));
        chk(r.tag, "new_flags", 32'(new_flags), 32'(r.fl));
      end
    end
  end

  task automatic set_cpu(input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] ss,
                         input logic [15:0] sp, input logic [15:0] fl);
    cpu_cs = cs; cpu_ip = ip; cpu_ss = ss; cpu_sp = sp; cpu_flags = fl;
  endtask

  task automatic expect_entry(input string tag, input bit via_intr, input logic [7:0] t);
    if (via_intr) exp_q.push_back('{1'b1, 1'b0, 20'h00000, 16'h0000, "R6"});
    exp_q.push_back('{1'b0, 1'b1, lin(cpu_ss, 16'(cpu_sp - 16'd2)), cpu_flags, "R2"});
    exp_q.push_back('{1'b0, 1'b1, lin(cpu_ss, 16'(cpu_sp - 16'd4)), cpu_cs, "R2"});
    exp_q.push_back('{1'b0, 1'b1, lin(cpu_ss, 16'(cpu_sp - 16'd6)), cpu_ip, "R2"});
    exp_q.push_back('{1'b0, 1'b0, 20'({t, 2'b00}), 16'h0000, "R3"});
    exp_q.push_back('{1'b0, 1'b0, 20'({t, 2'b00}) + 20'd2, 16'h0000, "R3"});
    res_q.push_back('{vcs(int'(t)), vip(int'(t)), 16'(cpu_sp - 16'd6), cpu_flags & 16'hFCFF, tag});
  endtask

  task automatic expect_return(input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] fl);
    exp_q.push_back('{1'b0, 1'b0, lin(cpu_ss, cpu_sp), 16'h0000, "R9"});
    exp_q.push_back('{1'b0, 1'b0, lin(cpu_ss, 16'(cpu_sp + 16'd2)), 16'h0000, "R9"});
    exp_q.push_back('{1'b0, 1'b0, lin(cpu_ss, 16'(cpu_sp + 16'd4)), 16'h0000, "R9"});
    res_q.push_back('{cs, ip, 16'(cpu_sp + 16'd6), fl, "R9"});
  endtask

  // mask bits: 0 div,1 bkpt,2 ovf,3 int,4 nmi,5 intr,6 step,7 iret
  task automatic fire(input logic [7:0] m);
    @(negedge clk);
    div_err = m[0]; bkpt_req = m[1]; ovf_req = m[2]; int_req = m[3];
    nmi_req = m[4]; intr_req = m[5]; step_done = m[6]; iret_req = m[7];
    @(negedge clk);
    div_err = 0; bkpt_req = 0; ovf_req = 0; int_req = 0;
    nmi_req = 0; intr_req = 0; step_done = 0; iret_req = 0;
  endtask

  task automatic settle();
    int n = 0;
    while ((exp_q.size() != 0 || res_q.size() != 0) && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (n >= 400) begin
      chk("R11", "sequence timeout", 32'h1, 32'h0);
      exp_q.delete();
      res_q.delete();
    end
    repeat (3) @(negedge clk);
    chk("R11", "idle after sequence", 32'(busy), 32'h0);
  endtask

  task automatic expect_quiet(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(tag, "busy stays low", 32'(busy), 32'h0);
      chk(tag, "mem_req stays low", 32'(mem_req), 32'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    div_err = 0; bkpt_req = 0; ovf_req = 0; int_req = 0; nmi_req = 0;
    intr_req = 0; step_done = 0; iret_req = 0; int_type = 8'h00;
    mem_rdata = 16'h0000; mem_ready = 1'b0;
    set_cpu(16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    for (int t = 0; t < 256; t++) begin
      bmem[20'(t * 4)]     = vip(t);
      bmem[20'(t * 4 + 2)] = vcs(t);
    end
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 32'h0);
    chk("R1", "done in reset", 32'(done), 32'h0);
    chk("R1", "mem_req in reset", 32'(mem_req), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 32'h0);

    // R5 R2 R3 R4: non-maskable entry, no wait states
    waits = 0;
    set_cpu(16'h1234, 16'h5678, 16'h1000, 16'h2000, 16'h0302);
    expect_entry("R4", 1'b0, 8'd2);
    fire(8'h10);
    chk("R11", "busy after accept", 32'(busy), 32'h1);
    settle();

    // R9: return from that frame, two wait states
    waits = 2;
    set_cpu(vcs(2), vip(2), 16'h1000, 16'h1FFA, 16'h0002);
    expect_return(16'h1234, 16'h5678, 16'h0302);
    fire(8'h80);
    settle();

    // R5: software interrupt operand
    waits = 1;
    int_type = 8'h21;
    set_cpu(16'h0A00, 16'h0100, 16'h2000, 16'h0800, 16'h0200);
    expect_entry("R5", 1'b0, 8'h21);
    fire(8'h08);
    settle();

    // R7: divide wins over non-maskable and maskable
    waits = 0;
    set_cpu(16'h0B00, 16'h0010, 16'h2000, 16'h0700, 16'h0200);
    expect_entry("R7", 1'b0, 8'd0);
    fire(8'h31);
    settle();
    expect_quiet("R7");

    // R7: breakpoint wins over overflow; R5: overflow alone
    expect_entry("R7", 1'b0, 8'd3);
    fire(8'h06);
    settle();
    expect_entry("R5", 1'b0, 8'd4);
    fire(8'h04);
    settle();

    // R6: maskable request with acknowledge cycle
    waits = 2;
    bus_type = 8'h47;
    set_cpu(16'h3000, 16'h0444, 16'h2000, 16'h0600, 16'h0281);
    expect_entry("R6", 1'b1, 8'h47);
    fire(8'h20);
    settle();

    // R6: maskable request with enable clear is dropped
    set_cpu(16'h3000, 16'h0444, 16'h2000, 16'h0600, 16'h0081);
    fire(8'h20);
    expect_quiet("R6");

    // R8: single-step with trace set, then with trace clear
    waits = 0;
    set_cpu(16'h4000, 16'h0008, 16'h2000, 16'h0500, 16'h0100);
    expect_entry("R8", 1'b0, 8'd1);
    fire(8'h40);
    settle();
    set_cpu(16'h4000, 16'h0008, 16'h2000, 16'h0500, 16'h0200);
    fire(8'h40);
    expect_quiet("R8");

    // R2: linear stack address wraps at 2^20
    waits = 1;
    set_cpu(16'h5000, 16'h0050, 16'hFFFF, 16'h0420, 16'h00C5);
    expect_entry("R2", 1'b0, 8'd2);
    fire(8'h10);
    settle();

    // R11: a request arriving while busy is ignored
    waits = 2;
    int_type = 8'h60;
    set_cpu(16'h6000, 16'h0600, 16'h2000, 16'h0400, 16'h0200);
    expect_entry("R11", 1'b0, 8'd2);
    fire(8'h10);
    fire(8'h08);
    settle();
    expect_quiet("R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule